// File: doc/BRIEF.md
# Dual-Channel DAC Update Controller

This block holds the control and data registers for a pair of 12-bit voltage-output converter cores and decides when a freshly written sample reaches each core. Software writes a 16-bit control word and a 16-bit sample word per channel over a single-cycle write bus and reads them back through a combinational read port. Each sample is right-justified; it is turned into a straight-binary 12-bit core code whether it arrives as an 8-bit or 12-bit value and whether it is unsigned or signed.

Four load policies are selectable per channel: load on the sample write itself, load once every channel of a linked group has a new sample, or load on a rising edge of one of two timer outputs. Under the three latched policies a channel must be enabled before it loads, and each load raises a ready flag that only a control write can lower. The flag, a per-channel interrupt enable and a global interrupt enable combine into one interrupt request. The amplifier field of the control word tells the analogue side whether to float, drive 0 V or drive the code.

Top module: `dac_pair_ctrl`

## Requirements
- R1: After reset both core codes are 0, both drive indications are 2'b00, the interrupt request is low and every register reads 0.
- R2: Address bit 1 picks the channel and address bit 0 picks the register (0 = control, 1 = sample); the control word reads back exactly as written, while the sample reads back with bits 15:12 as zero.
- R3: With load field (control bits 11:10) equal to 0 the core code takes the converted sample at the clock edge of the sample write, whatever the enable bit (bit 1) holds, and the ready flag (bit 2) stays 0.
- R4: With resolution bit 12 at 0, format bit 4 at 0 passes sample bits 11:0 unchanged and format bit 4 at 1 inverts bit 11 (0x800 gives 0x000, 0x7FF gives 0xFFF).
- R5: With resolution bit 12 at 1, sample bits 7:0 fill core code bits 11:4, bits 3:0 are zero, sample bits 11:8 are ignored, and in signed format bit 7 is inverted.
- R6: With load field 1 on both channels and link bit 0 of channel 0 set, neither core changes until both samples have been written, in either order; both then load on the edge of the second write.
- R7: With load field 1 and channel 0's link bit clear, each channel loads on the edge of its own sample write; link bit 0 of channel 1 has no effect.
- R8: With load field 2 (trigger A) or 3 (trigger B) the stored sample loads on the third clock edge after the trigger input rises, not earlier, and the other trigger does not load it.
- R9: With a non-zero load field and enable bit 1 at 0, no trigger or group event changes the core code.
- R10: Every load under a non-zero load field sets the ready flag; a sample write leaves it set and only a control write with bit 2 at 0 clears it.
- R11: The interrupt request is high exactly when some channel has its ready flag and its interrupt enable (bit 3) set and the global interrupt enable is high.
- R12: Amplifier field bits 7:5 of 000 give drive indication 2'b00 (float), 001 gives 2'b01 (0 V), any other value gives 2'b10 (drive code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Bit 1 channel, bit 0 register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| trig_a | input | 1 | Asynchronous timer output A |
| trig_b | input | 1 | Asynchronous timer output B |
| gie | input | 1 | Global interrupt enable |
| dac0_code | output | 12 | Straight-binary code for core 0 |
| dac1_code | output | 12 | Straight-binary code for core 1 |
| dac0_drive | output | 2 | Output mode for core 0 |
| dac1_drive | output | 2 | Output mode for core 1 |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, immediate loads and group loads take effect at the very edge that samples the write strobe, so the bench checks core codes and flags at the falling edge straight after that write. A trigger load passes two synchronizer flops and an edge register, so the code moves on the third rising edge after the trigger goes high; the bench samples once after the second edge to see the old code and once after the third to see the new one. Read data and the interrupt request are combinational from registers and the global enable, so they are checked one time step after the address or enable is changed.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  localparam int REG_W    = 16;
  localparam int CODE_W   = 12;
  localparam int NARROW_W = 8;
  localparam int NCH      = 2;

  // control field positions
  localparam int B_RES  = 12;
  localparam int B_LDHI = 11;
  localparam int B_LDLO = 10;
  localparam int B_AMPH = 7;
  localparam int B_AMPL = 5;
  localparam int B_FMT  = 4;
  localparam int B_IE   = 3;
  localparam int B_FLAG = 2;
  localparam int B_EN   = 1;
  localparam int B_LINK = 0;

  typedef enum logic [1:0] {
    LD_WRITE = 2'd0,
    LD_GROUP = 2'd1,
    LD_TRGA  = 2'd2,
    LD_TRGB  = 2'd3
  } load_sel_e;

  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_ZERO = 2'b01,
    DRV_CODE = 2'b10
  } drive_e;
endpackage

// File: rtl/dacu_sync_edge.sv
module dacu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_nx;
  logic              prev_q, prev_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], async_in};
    prev_nx = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_nx;
      prev_q <= prev_nx;
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dacu_code_map.sv
module dacu_code_map #(
  parameter int DATA_W   = 12,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              narrow,
  input  logic              signed_fmt,
  output logic [DATA_W-1:0] code
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   wide_c;
  logic [NARROW_W-1:0] slim_c;

  always_comb begin
    wide_c = raw;
    wide_c[DATA_W-1] = raw[DATA_W-1] ^ signed_fmt;
    slim_c = raw[NARROW_W-1:0];
    slim_c[NARROW_W-1] = raw[NARROW_W-1] ^ signed_fmt;
    code = narrow ? {slim_c, {PAD_W{1'b0}}} : wide_c;
  end
endmodule

// File: rtl/dacu_channel.sv
module dacu_channel
  import dacu_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CODE_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_dat,
  input  logic [RW-1:0] wdata,
  input  logic          rise_a,
  input  logic          rise_b,
  input  logic          grp_fire,
  output logic          grp_ready,
  output logic [RW-1:0] ctl_rd,
  output logic [RW-1:0] dat_rd,
  output logic [CW-1:0] code,
  output logic [1:0]    drive
);
  localparam int ZPAD = RW - CW;

  logic [RW-1:0] ctl_q, ctl_nx;
  logic [CW-1:0] dat_q, dat_nx;
  logic [CW-1:0] code_q, code_nx, code_new;
  logic          pend_q, pend_nx;
  logic          ctl_en, dat_en, code_en;
  logic          load_ev, set_flag, enabled;
  load_sel_e     lsel;

  assign lsel    = load_sel_e'(ctl_q[B_LDHI:B_LDLO]);
  assign enabled = ctl_q[B_EN];

  dacu_code_map #(.DATA_W(CW), .NARROW_W(NW)) u_map (
    .raw        (dat_nx),
    .narrow     (ctl_q[B_RES]),
    .signed_fmt (ctl_q[B_FMT]),
    .code       (code_new)
  );

  always_comb begin
    dat_nx = wr_dat ? wdata[CW-1:0] : dat_q;
    dat_en = wr_dat;

    unique case (lsel)
      LD_WRITE: load_ev = wr_dat;
      LD_GROUP: load_ev = grp_fire & enabled;
      LD_TRGA:  load_ev = rise_a & enabled;
      LD_TRGB:  load_ev = rise_b & enabled;
      default:  load_ev = 1'b0;
    endcase

    set_flag = load_ev & (lsel != LD_WRITE);
    code_en  = load_ev;
    code_nx  = code_new;

    ctl_nx = wr_ctl ? wdata : ctl_q;
    if (set_flag) ctl_nx[B_FLAG] = 1'b1;
    ctl_en = wr_ctl | set_flag;

    grp_ready = (lsel == LD_GROUP) & (pend_q | wr_dat);
    pend_nx   = grp_ready & ~grp_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      dat_q  <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_nx;
      if (dat_en)  dat_q  <= dat_nx;
      if (code_en) code_q <= code_nx;
      pend_q <= pend_nx;
    end
  end

  always_comb begin
    unique case (ctl_q[B_AMPH:B_AMPL])
      3'b000:  drive = DRV_HIZ;
      3'b001:  drive = DRV_ZERO;
      default: drive = DRV_CODE;
    endcase
  end

  assign ctl_rd = ctl_q;
  assign dat_rd = {{ZPAD{1'b0}}, dat_q};
  assign code   = code_q;
endmodule

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
  import dacu_pkg::*;
#(
  parameter int RW          = REG_W,
  parameter int CW          = CODE_W,
  parameter int NW          = NARROW_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  input  logic          trig_a,
  input  logic          trig_b,
  input  logic          gie,
  output logic [CW-1:0] dac0_code,
  output logic [CW-1:0] dac1_code,
  output logic [1:0]    dac0_drive,
  output logic [1:0]    dac1_drive,
  output logic          irq
);
  localparam int NTRIG = 2;

  logic [1:0]                rst_pipe_q;
  logic                      rst_int_n;
  logic [NTRIG-1:0]          trig_in, trig_rise;
  logic [NCH-1:0][RW-1:0]    ctl_all, dat_all;
  logic [NCH-1:0][CW-1:0]    code_all;
  logic [NCH-1:0][1:0]       drive_all;
  logic [NCH-1:0]            ready_v, fire_v, link_v, fwd_v, bwd_v;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign trig_in = {trig_b, trig_a};

  for (genvar t = 0; t < NTRIG; t++) begin : g_trig
    dacu_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .async_in (trig_in[t]),
      .rise     (trig_rise[t])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = bus_we & (bus_addr[1] == 1'(c));
    dacu_channel #(.RW(RW), .CW(CW), .NW(NW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_ctl    (sel_c & ~bus_addr[0]),
      .wr_dat    (sel_c & bus_addr[0]),
      .wdata     (bus_wdata),
      .rise_a    (trig_rise[0]),
      .rise_b    (trig_rise[1]),
      .grp_fire  (fire_v[c]),
      .grp_ready (ready_v[c]),
      .ctl_rd    (ctl_all[c]),
      .dat_rd    (dat_all[c]),
      .code      (code_all[c]),
      .drive     (drive_all[c])
    );
  end

  // a set link bit joins a channel to the next higher one; a run fires
  // only when every member of it is ready
  always_comb begin
    link_v = '0;
    for (int c = 0; c < NCH - 1; c++) link_v[c] = ctl_all[c][B_LINK];
    fwd_v[0] = ready_v[0];
    for (int c = 1; c < NCH; c++)
      fwd_v[c] = ready_v[c] & (~link_v[c-1] | fwd_v[c-1]);
    bwd_v[NCH-1] = ready_v[NCH-1];
    for (int c = NCH - 2; c >= 0; c--)
      bwd_v[c] = ready_v[c] & (~link_v[c] | bwd_v[c+1]);
    fire_v = fwd_v & bwd_v;
  end

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NCH; c++)
      irq = irq | (ctl_all[c][B_FLAG] & ctl_all[c][B_IE]);
    irq = irq & gie;
  end

  assign bus_rdata  = bus_addr[0] ? dat_all[bus_addr[1]] : ctl_all[bus_addr[1]];
  assign dac0_code  = code_all[0];
  assign dac1_code  = code_all[1];
  assign dac0_drive = drive_all[0];
  assign dac1_drive = drive_all[1];
endmodule

// File: rtl/dac_pair_ctrl_chk.sv
module dac_pair_ctrl_chk
  import dacu_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic [1:0]             bus_addr,
  input logic [3:0]             rdata_pad,
  input logic                   gie,
  input logic                   irq,
  input logic [NCH-1:0][1:0]    lsel_all,
  input logic [NCH-1:0]         en_all,
  input logic [NCH-1:0]         flag_all,
  input logic [NCH-1:0][CW-1:0] code_all,
  input logic                   rise_a,
  input logic                   rise_b
);
  assert_rdata_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[0] |-> (rdata_pad == 4'd0));

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_code_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_all[c]) |-> ($past(bus_we) || $past(rise_a) || $past(rise_b)));

    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(code_all[c]) && !$past(en_all[c])) |-> ($past(lsel_all[c]) == 2'd0));

    assert_flag_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_all[c]) |-> (($past(lsel_all[c]) != 2'd0) ||
        $past(bus_we && bus_addr == {1'(c), 1'b0})));

    assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_all[c]) |-> $past(bus_we && bus_addr == {1'(c), 1'b0}));
  end
endmodule

bind dac_pair_ctrl dac_pair_ctrl_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .rdata_pad (bus_rdata[15:12]),
  .gie       (gie),
  .irq       (irq),
  .lsel_all  ({ctl_all[1][11:10], ctl_all[0][11:10]}),
  .en_all    ({ctl_all[1][1], ctl_all[0][1]}),
  .flag_all  ({ctl_all[1][2], ctl_all[0][2]}),
  .code_all  (code_all),
  .rise_a    (trig_rise[0]),
  .rise_b    (trig_rise[1])
);

// File: tb/sim_dac_pair_ctrl.sv
module sim_dac_pair_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        trig_a, trig_b, gie;
  logic [11:0] dac0_code, dac1_code;
  logic [1:0]  dac0_drive, dac1_drive;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  dac_pair_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_a(trig_a),
    .trig_b(trig_b), .gie(gie), .dac0_code(dac0_code), .dac1_code(dac1_code),
    .dac0_drive(dac0_drive), .dac1_drive(dac1_drive), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic trig_raise(input int which);
    @(negedge clk);
    if (which == 0) trig_a = 1'b1; else trig_b = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig_land();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig_drop();
    trig_a = 1'b0; trig_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 code0", dac0_code, 0);
    chk("R1 code1", dac1_code, 0);
    chk("R1 drive0", dac0_drive, 0);
    chk("R1 drive1", dac1_drive, 0);
    chk("R1 irq", irq, 0);
    rd_chk("R1 ctl0", 2'd0, 16'h0000);
    rd_chk("R1 dat1", 2'd3, 16'h0000);
  endtask

  task automatic t_readback();
    wr(2'd1, 16'hFABC);
    rd_chk("R2 dat pad", 2'd1, 16'h0ABC);
    chk("R3 immediate disabled", dac0_code, 12'hABC);
    wr(2'd2, 16'hA5E0);
    rd_chk("R2 ctl full", 2'd2, 16'hA5E0);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_immediate();
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'h0123);
    chk("R3 load on write", dac0_code, 12'h123);
    rd_chk("R3 no flag", 2'd0, 16'h0040);
    wr(2'd0, 16'h0050);
    wr(2'd1, 16'h0800);
    chk("R4 signed min", dac0_code, 12'h000);
    wr(2'd1, 16'h07FF);
    chk("R4 signed max", dac0_code, 12'hFFF);
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'h0800);
    chk("R4 unsigned", dac0_code, 12'h800);
  endtask

  task automatic t_narrow();
    wr(2'd0, 16'h1040);
    wr(2'd1, 16'h0FA5);
    chk("R5 narrow unsigned", dac0_code, 12'hA50);
    wr(2'd0, 16'h1050);
    wr(2'd1, 16'h0080);
    chk("R5 narrow signed min", dac0_code, 12'h000);
    wr(2'd1, 16'h0F7F);
    chk("R5 narrow signed max", dac0_code, 12'hFF0);
  endtask

  task automatic t_amp();
    chk("R12 ch1 float", dac1_drive, 2'b00);
    wr(2'd2, 16'h0020);
    chk("R12 ch1 zero", dac1_drive, 2'b01);
    wr(2'd2, 16'h00E0);
    chk("R12 ch1 code", dac1_drive, 2'b10);
    chk("R12 ch0 code", dac0_drive, 2'b10);
  endtask

  task automatic t_group();
    wr(2'd0, 16'h0443);
    wr(2'd2, 16'h0442);
    wr(2'd1, 16'h0111);
    chk("R6 first write holds ch0", dac0_code, 12'hFF0);
    chk("R6 first write holds ch1", dac1_code, 12'h000);
    wr(2'd3, 16'h0222);
    chk("R6 both load ch0", dac0_code, 12'h111);
    chk("R6 both load ch1", dac1_code, 12'h222);
    rd_chk("R10 flag set ch0", 2'd0, 16'h0447);
    rd_chk("R10 flag set ch1", 2'd2, 16'h0446);
    wr(2'd0, 16'h0443);
    wr(2'd2, 16'h0442);
    wr(2'd3, 16'h00AB);
    chk("R6 reverse order holds", dac1_code, 12'h222);
    wr(2'd1, 16'h00CD);
    chk("R6 reverse order ch0", dac0_code, 12'h0CD);
    chk("R6 reverse order ch1", dac1_code, 12'h0AB);
  endtask

  task automatic t_ungrouped();
    wr(2'd0, 16'h0442);
    wr(2'd2, 16'h0443);
    wr(2'd3, 16'h0333);
    chk("R7 ch1 own load", dac1_code, 12'h333);
    chk("R7 ch0 untouched", dac0_code, 12'h0CD);
    wr(2'd1, 16'h0444);
    chk("R7 ch0 own load", dac0_code, 12'h444);
  endtask

  task automatic t_trigger();
    wr(2'd0, 16'h0842);
    wr(2'd2, 16'h0C42);
    wr(2'd1, 16'h0555);
    chk("R8 write alone holds", dac0_code, 12'h444);
    wr(2'd3, 16'h0666);
    trig_raise(1);
    chk("R8 B not yet", dac1_code, 12'h333);
    trig_land();
    chk("R8 B loads", dac1_code, 12'h666);
    chk("R8 B ignored by ch0", dac0_code, 12'h444);
    trig_drop();
    trig_raise(0);
    chk("R8 A not yet", dac0_code, 12'h444);
    trig_land();
    chk("R8 A loads", dac0_code, 12'h555);
    trig_drop();
  endtask

  task automatic t_enable();
    wr(2'd0, 16'h0840);
    wr(2'd1, 16'h0777);
    trig_raise(0);
    trig_land();
    chk("R9 disabled holds", dac0_code, 12'h555);
    rd_chk("R9 no flag", 2'd0, 16'h0840);
    trig_drop();
  endtask

  task automatic t_irq();
    gie = 1'b0;
    wr(2'd0, 16'h084A);
    trig_raise(0);
    trig_land();
    chk("R10 enabled load", dac0_code, 12'h777);
    rd_chk("R10 flag after trigger", 2'd0, 16'h084E);
    chk("R11 gie low", irq, 0);
    trig_drop();
    gie = 1'b1;
    #1;
    chk("R11 all set", irq, 1);
    wr(2'd1, 16'h0100);
    chk("R10 data write keeps flag", irq, 1);
    wr(2'd0, 16'h084A);
    chk("R10 ctl write clears", irq, 0);
    wr(2'd0, 16'h0842);
    trig_raise(0);
    trig_land();
    trig_drop();
    rd_chk("R10 flag without ie", 2'd0, 16'h0846);
    chk("R11 ie low", irq, 0);
    wr(2'd0, 16'h004A);
    wr(2'd1, 16'h0200);
    chk("R3 immediate after latched", dac0_code, 12'h200);
    chk("R3 immediate no irq", irq, 0);
    rd_chk("R3 immediate no flag", 2'd0, 16'h004A);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 16'h0;
    trig_a = 1'b0; trig_b = 1'b0; gie = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_immediate();
    t_narrow();
    t_amp();
    t_group();
    t_ungrouped();
    t_trigger();
    t_enable();
    t_irq();
    finish_run();
  end
endmodule